// File: doc/BRIEF.md
# Tone-Shift Audio Demodulator with Bit-Timing Recovery

This block turns a stream of signed audio samples, carrying a two-tone frequency-shift keyed signal, into recovered data bits. Each sample arrives with a one-cycle strobe at about 9600 samples per second. The block multiplies the sample by the sample taken four strobes before it. It smooths that product with a small recursive low-pass stage and slices the filter output to one bit per sample. A product that stays positive or negative over time marks which tone is present.

A phase counter tracks bit timing at eight samples per bit. It is nudged one step toward the centre of the bit whenever the sliced stream shows a transition. Each time the counter wraps, the block makes a 2-of-3 majority decision on the newest sliced bits. The decided bits are then differentially decoded. A repeated level yields 1 and a change yields 0. The block presents each result with a one-cycle valid pulse, for use by a downstream frame parser.

Top module: `afskDemod`

## Requirements
- R1: While rstN is low, bitValid and bitOut are 0. The delay line, the filter, the sliced history, the phase counter and the decided history all clear to zero.
- R2: On each strobe, the product is sampleIn times the sample seen four strobes earlier, arithmetically shifted right by 2. The delay line starts as zeros, so the first four products after reset are zero.
- R3: On each strobe, the filter output becomes the previous product, plus the current product, plus the previous output arithmetically shifted right by 1. The sliced bit is 1 when that new output is greater than zero, and it shifts into the sliced history at bit 0.
- R4: A transition is detected when sliced-history bit 0 differs from bit 2 and bit 1 differs from bit 3, taking the history after this strobe's shift. On a transition, the phase counter is first raised by 1 if it is below 32, or lowered by 1 otherwise. On every strobe it then advances by 8.
- R5: When the advanced phase reaches 64 or more, it wraps by subtracting 64 and a bit decision is made. The decided bit is 1 when at least two of sliced-history bits 0, 1 and 2 are 1.
- R6: bitValid is high for exactly the one clock cycle after the strobe edge that made a decision, and low in all other cycles.
- R7: With each decision, bitOut becomes 1 if the new decided bit equals the previous decided bit and 0 otherwise. The previous decided bit after reset is 0. bitOut holds its value between decisions.
- R8: In a cycle without sampleValid, sampleIn has no effect and no state or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a new audio sample |
| sampleIn | input | 8 | Signed two's-complement audio sample |
| bitValid | output | 1 | One-cycle pulse marking a new recovered bit |
| bitOut | output | 1 | Differentially decoded recovered bit |

## Verification
The assertions take two things for granted. First, sampleValid is a single-cycle strobe sampled on the rising clock edge. Second, sampleIn matters only in strobe cycles. Given those, bitValid can follow only a strobe and bitOut can move only with bitValid. The stimulus drives inputs on the falling edge and mixes strobe spacings of one to four cycles, including back-to-back strobes. It toggles sampleIn freely between strobes. It keeps sample values within the signed 8-bit range, including the most negative value, so the filter sum never wraps.

// File: rtl/afskDemodPkg.sv
package afskDemodPkg;

  typedef struct packed {
    logic advance;
    logic decide;
  } strobeT;

  function automatic logic majority3(input logic [2:0] b);
    return (b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2]);
  endfunction

endpackage

// File: rtl/afskDemodDatapath.sv
module afskDemodDatapath
  import afskDemodPkg::*;
#(
  parameter int SampleW   = 8,
  parameter int DelayTaps = 4,
  parameter int ProdShift = 2,
  parameter int AccW      = 16,
  parameter int HistW     = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobeT                    strobe,
  input  logic signed [SampleW-1:0] sampleIn,
  output logic [HistW-1:0]          histNext,
  output logic                      bitValid,
  output logic                      bitOut
);

  localparam int ProdW = 2 * SampleW;

  logic [DelayTaps-1:0][SampleW-1:0] delayQ;
  logic signed [SampleW-1:0] delayed;
  logic signed [ProdW-1:0]   prodFull;
  logic signed [AccW-1:0]    prodNow;
  logic signed [AccW-1:0]    prodPrevQ;
  logic signed [AccW-1:0]    filtQ;
  logic signed [AccW-1:0]    filtNext;
  logic [HistW-2:0]          histQ;
  logic                      sliced;
  logic                      decided;
  logic                      lastDecQ;

  assign delayed  = signed'(delayQ[DelayTaps-1]);
  assign prodFull = sampleIn * delayed;
  assign prodNow  = AccW'(prodFull >>> ProdShift);
  assign filtNext = prodPrevQ + prodNow + (filtQ >>> 1);
  assign sliced   = (filtNext > 0);
  assign histNext = {histQ, sliced};
  assign decided  = majority3(histNext[2:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayQ <= '0;
    end else if (strobe.advance) begin
      delayQ[0] <= sampleIn;
      for (int i = 1; i < DelayTaps; i++) begin
        delayQ[i] <= delayQ[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodPrevQ <= '0;
      filtQ     <= '0;
      histQ     <= '0;
    end else if (strobe.advance) begin
      prodPrevQ <= prodNow;
      filtQ     <= filtNext;
      histQ     <= histNext[HistW-2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastDecQ <= 1'b0;
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      bitValid <= strobe.advance & strobe.decide;
      if (strobe.advance && strobe.decide) begin
        lastDecQ <= decided;
        bitOut   <= (decided == lastDecQ);
      end
    end
  end

endmodule

// File: rtl/afskDemodControl.sv
module afskDemodControl
  import afskDemodPkg::*;
#(
  parameter int PhaseSteps = 64,
  parameter int PhaseStep  = 8,
  parameter int Nudge      = 1,
  parameter int HistW      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [HistW-1:0] histNext,
  output strobeT           strobe
);

  localparam int PhaseW = $clog2(PhaseSteps) + 1;
  localparam logic [PhaseW-1:0] Half  = PhaseW'(PhaseSteps / 2);
  localparam logic [PhaseW-1:0] Wrap  = PhaseW'(PhaseSteps);
  localparam logic [PhaseW-1:0] Step  = PhaseW'(PhaseStep);
  localparam logic [PhaseW-1:0] Nudg  = PhaseW'(Nudge);

  logic [PhaseW-1:0] phaseQ;
  logic [PhaseW-1:0] phaseAdj;
  logic [PhaseW-1:0] phaseSum;
  logic              transition;
  logic              wrapNow;

  assign transition = (histNext[0] ^ histNext[2]) & (histNext[1] ^ histNext[3]);
  assign phaseAdj   = !transition ? phaseQ :
                      (phaseQ < Half) ? phaseQ + Nudg : phaseQ - Nudg;
  assign phaseSum   = phaseAdj + Step;
  assign wrapNow    = (phaseSum >= Wrap);

  assign strobe.advance = sampleValid;
  assign strobe.decide  = sampleValid & wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (sampleValid) begin
      phaseQ <= wrapNow ? phaseSum - Wrap : phaseSum;
    end
  end

endmodule

// File: rtl/afskDemod.sv
module afskDemod
  import afskDemodPkg::*;
#(
  parameter int SampleW    = 8,
  parameter int DelayTaps  = 4,
  parameter int ProdShift  = 2,
  parameter int AccW       = 16,
  parameter int PhaseSteps = 64,
  parameter int PhaseStep  = 8,
  parameter int Nudge      = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  input  logic signed [SampleW-1:0] sampleIn,
  output logic                      bitValid,
  output logic                      bitOut
);

  localparam int HistW = 4;

  strobeT           strobe;
  logic [HistW-1:0] histNext;

  afskDemodControl #(
    .PhaseSteps(PhaseSteps), .PhaseStep(PhaseStep), .Nudge(Nudge), .HistW(HistW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .histNext(histNext), .strobe(strobe)
  );

  afskDemodDatapath #(
    .SampleW(SampleW), .DelayTaps(DelayTaps), .ProdShift(ProdShift),
    .AccW(AccW), .HistW(HistW)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .histNext(histNext), .bitValid(bitValid), .bitOut(bitOut)
  );

endmodule

// File: rtl/afskDemodChk.sv
module afskDemodChk (
  input logic clk,
  input logic rstN,
  input logic sampleValid,
  input logic bitValid,
  input logic bitOut
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> (!bitValid && !bitOut));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  p_pulse_after_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !bitValid);

  p_out_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> $stable(bitOut));

  p_idle_no_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(bitOut));

endmodule

bind afskDemod afskDemodChk chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .bitValid(bitValid), .bitOut(bitOut)
);

// File: tb/afskDemod_test.sv
module afskDemod_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [7:0] sampleIn = '0;
  logic bitValid, bitOut;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // reference model state
  int dq[$];
  int mPrevProd, mFilt, mHist, mPhase, mLastDec;
  logic expValid, expBit;

  always #10 clk = ~clk;

  afskDemod uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .bitValid(bitValid), .bitOut(bitOut)
  );

  task automatic check(input string t, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    dq = {0, 0, 0, 0};
    mPrevProd = 0; mFilt = 0; mHist = 0; mPhase = 0; mLastDec = 0;
    expValid = 1'b0; expBit = 1'b0;
  endtask

  task automatic modelStrobe(input int s);
    int old, prod, y, ones, dec;
    old = dq.pop_back();
    dq.push_front(s);
    prod = (s * old) >>> 2;
    y = mPrevProd + prod + (mFilt >>> 1);
    mPrevProd = prod;
    mFilt = y;
    mHist = ((mHist << 1) | (y > 0 ? 1 : 0)) & 15;
    if ((((mHist ^ (mHist >> 2)) & 3) == 3)) begin
      if (mPhase < 32) mPhase = mPhase + 1;
      else mPhase = mPhase - 1;
    end
    mPhase = mPhase + 8;
    expValid = 1'b0;
    if (mPhase >= 64) begin
      mPhase = mPhase % 64;
      ones = (mHist & 1) + ((mHist >> 1) & 1) + ((mHist >> 2) & 1);
      dec = (ones >= 2) ? 1 : 0;
      expBit = (dec == mLastDec);
      mLastDec = dec;
      expValid = 1'b1;
    end
  endtask

  // one clock: drive at negedge, step model, compare at next negedge
  task automatic cycle(input logic v, input int s);
    sampleValid = v;
    sampleIn = 8'(s);
    if (v) modelStrobe(s);
    else expValid = 1'b0;
    @(negedge clk);
    check(tag, bitValid, expValid, "bitValid");
    check(tag, bitOut, expBit, "bitOut");
  endtask

  // one sample followed by idle cycles with junk on sampleIn
  task automatic sample(input int s, input int gap);
    cycle(1'b1, s);
    for (int g = 0; g < gap; g++) cycle(1'b0, (s * 7 + g * 37) % 128);
  endtask

  function automatic int tone(input int n, input real freq);
    return int'(100.0 * $sin(2.0 * 3.14159265 * freq * n / 9600.0));
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pulses, n, bitIdx;
    logic level;
    modelReset();
    @(negedge clk);
    @(negedge clk);
    tag = "R1";
    check(tag, bitValid, 1'b0, "bitValid in reset");
    check(tag, bitOut, 1'b0, "bitOut in reset");
    rstN = 1'b1;
    @(negedge clk);

    // R8: activity on sampleIn without a strobe
    tag = "R8";
    for (int i = 0; i < 30; i++) cycle(1'b0, i * 9 - 120);

    // R2: DC input; first four products zero, then positive
    tag = "R2";
    pulses = 0;
    for (int i = 0; i < 64; i++) begin
      sample(100, 2);
    end
    // R6: count pulses over 64 more steady samples: exactly 8
    tag = "R6";
    for (int i = 0; i < 64; i++) begin
      cycle(1'b1, 100);
      if (bitValid) pulses++;
      cycle(1'b0, -5);
    end
    checks++;
    if (pulses != 8) begin
      errors++;
      $display("FAIL R6 pulse count: actual=%0d expected=8", pulses);
    end
    // R7: steady level gives repeated decided bits, so bitOut is 1
    check("R7", bitOut, 1'b1, "steady level output");

    // R2: extreme negative samples
    tag = "R2";
    for (int i = 0; i < 40; i++) sample((i % 2) ? -128 : 127, 1);

    // R3: mark tone, then space tone, strobes back to back
    tag = "R3";
    for (int i = 0; i < 96; i++) sample(tone(i, 1200.0), 0);
    for (int i = 0; i < 96; i++) sample(tone(i, 2200.0), 0);

    // R4 and R5: keyed tones, bit pattern changing tone per bit, mixed gaps
    tag = "R4";
    n = 0;
    level = 1'b0;
    for (bitIdx = 0; bitIdx < 80; bitIdx++) begin
      if (((bitIdx * 5 + 3) % 7) < 3) level = ~level;
      for (int k = 0; k < 8; k++) begin
        sample(tone(n, level ? 2200.0 : 1200.0), (n % 4));
        n++;
      end
    end

    // R5: pseudo-random samples with slightly uneven bit length
    tag = "R5";
    for (int i = 0; i < 400; i++) sample(((i * 73 + 29) % 256) - 128, (i % 3));

    // R7: alternating sign blocks of 9 samples
    tag = "R7";
    for (int i = 0; i < 180; i++) sample(((i / 9) % 2) ? 90 : -90, 1);

    // R8: long idle stretch with junk, outputs must not move
    tag = "R8";
    for (int i = 0; i < 50; i++) cycle(1'b0, 127 - i);

    // R1: reset mid-stream clears everything
    rstN = 1'b0;
    modelReset();
    @(negedge clk);
    check("R1", bitValid, 1'b0, "bitValid after reset");
    check("R1", bitOut, 1'b0, "bitOut after reset");
    rstN = 1'b1;
    tag = "R1";
    for (int i = 0; i < 40; i++) sample(60, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule